// File: doc/BRIEF.md
# Interleaved 2D Block Pixel Memory

This block is an on-chip image store built from a grid of small memory banks. It holds one image of 8-bit pixels and serves a square 4x4 neighbourhood on every clock, starting at any pixel coordinate the caller names. Each new request may be unrelated to the one before it. This suits tracking and warping engines that fetch small patches at scattered positions.

Pixels are spread over the banks by their low coordinate bits in both directions. Any 4x4 window therefore touches every bank exactly once, whether or not it is aligned to the bank grid. Each bank works out its own word address from the window origin: it adds one to the column or row index when the window wraps past that bank. A rotation network then puts the sixteen bank outputs into raster order and registers them. A single-pixel write port loads or updates the image. The caller keeps every window inside the image; positions outside it are not handled.

Top module: `pxl_block_mem`

## Requirements
- R1: For a read at (x0, y0), output element k = r*4 + c, held in `rd_data_o[k*8 +: 8]`, is the pixel at (x0 + c, y0 + r).
- R2: Any origin with x0 in 0..W-4 and y0 in 0..H-4 is served correctly, aligned or not, with the same latency.
- R3: A new read may be issued on every clock with an unrelated origin, and one full block is returned per clock.
- R4: `rd_valid_o` is high in exactly the cycle after the second rising edge that follows a sampled `rd_en_i`, and low otherwise.
- R5: A write of `wr_data_i` to (`wr_x_i`, `wr_y_i`) is seen by every read sampled on a later edge.
- R6: A read sampled on the same edge as a write to one of its pixels returns that pixel's previous value.
- R7: After reset, `rd_valid_o` is 0 and `rd_data_o` is 0. `rd_data_o` keeps the last returned block in every cycle in which `rd_valid_o` is low.
- R8: A write changes only the addressed pixel; every other pixel keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Pixel write strobe |
| wr_x_i | input | log2(IMG_W) | Write column |
| wr_y_i | input | log2(IMG_H) | Write row |
| wr_data_i | input | PIX_W | Write pixel value |
| rd_en_i | input | 1 | Block read request |
| rd_x_i | input | log2(IMG_W) | Window origin column |
| rd_y_i | input | log2(IMG_H) | Window origin row |
| rd_valid_o | output | 1 | Block on `rd_data_o` is new this cycle |
| rd_data_o | output | BLK*BLK*PIX_W | Block in raster order, element 0 in the low bits |

## Verification
A bank address that misses its wrap increment returns pixels from the wrong 4x4 tile. This shows up only at unaligned origins, two cycles after the request. For that reason every legal origin is swept. A wrong rotation offset permutes elements inside a correct block, and this is caught on the same cycle by comparing every element. A pipeline-valid or write-ordering fault shows as a strobe one cycle early or late. It can also show as a block carrying the new value of a pixel written in the same cycle as the read.

// File: rtl/pxl_pkg.sv
package pxl_pkg;

  // Flat lane number of a bank sitting at (col, row) in a side x side grid.
  function automatic int unsigned lane_of(int unsigned col, int unsigned row,
                                          int unsigned side);
    return row * side + col;
  endfunction

endpackage

// File: rtl/pxl_wr_route.sv
module pxl_wr_route #(
  parameter int BLK = 4,
  parameter int XW  = 6,
  parameter int YW  = 6,
  localparam int BW = $clog2(BLK),
  localparam int NB = BLK * BLK,
  localparam int AW = (XW - BW) + (YW - BW)
) (
  input  logic          wr_en_i,
  input  logic [XW-1:0] x_i,
  input  logic [YW-1:0] y_i,
  output logic [NB-1:0] we_o,
  output logic [AW-1:0] waddr_o
);

  logic [2*BW-1:0] lane_sel;

  assign lane_sel = {y_i[BW-1:0], x_i[BW-1:0]};
  assign waddr_o  = {y_i[YW-1:BW], x_i[XW-1:BW]};

  for (genvar b = 0; b < NB; b++) begin : g_we
    assign we_o[b] = wr_en_i && (lane_sel == (2*BW)'(b));
  end

endmodule

// File: rtl/pxl_rd_addr.sv
module pxl_rd_addr #(
  parameter int BLK = 4,
  parameter int XW  = 6,
  parameter int YW  = 6,
  localparam int BW = $clog2(BLK),
  localparam int NB = BLK * BLK,
  localparam int CW = XW - BW,
  localparam int RW = YW - BW,
  localparam int AW = CW + RW
) (
  input  logic [XW-1:0]    x_i,
  input  logic [YW-1:0]    y_i,
  output logic [NB*AW-1:0] raddr_o
);
  import pxl_pkg::*;

  logic [BW-1:0] x_off, y_off;
  logic [CW-1:0] col_base;
  logic [RW-1:0] row_base;

  assign x_off    = x_i[BW-1:0];
  assign y_off    = y_i[BW-1:0];
  assign col_base = x_i[XW-1:BW];
  assign row_base = y_i[YW-1:BW];

  for (genvar j = 0; j < BLK; j++) begin : g_row
    for (genvar i = 0; i < BLK; i++) begin : g_col
      localparam int L = lane_of(i, j, BLK);
      logic [CW-1:0] col;
      logic [RW-1:0] row;
      // Banks left of the window start belong to the next tile over.
      assign col = col_base + CW'(BW'(i) < x_off);
      assign row = row_base + RW'(BW'(j) < y_off);
      assign raddr_o[L*AW +: AW] = {row, col};
    end
  end

endmodule

// File: rtl/pxl_bank.sv
module pxl_bank #(
  parameter int DW = 8,
  parameter int AW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem [DEPTH];

  // Read-first: a same-edge write is not seen by this read.
  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/pxl_reorder.sv
module pxl_reorder #(
  parameter int BLK = 4,
  parameter int DW  = 8,
  localparam int BW = $clog2(BLK),
  localparam int NB = BLK * BLK
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid_i,
  input  logic [BW-1:0] xo_i,
  input  logic [BW-1:0] yo_i,
  input  logic [NB*DW-1:0] lanes_i,
  output logic          out_valid_o,
  output logic [NB*DW-1:0] out_data_o
);

  logic [DW-1:0]    lane_a [NB];
  logic [NB*DW-1:0] perm;

  for (genvar b = 0; b < NB; b++) begin : g_unpack
    assign lane_a[b] = lanes_i[b*DW +: DW];
  end

  for (genvar r = 0; r < BLK; r++) begin : g_r
    for (genvar c = 0; c < BLK; c++) begin : g_c
      logic [BW-1:0] scol, srow;
      assign scol = xo_i + BW'(c);
      assign srow = yo_i + BW'(r);
      assign perm[(r*BLK + c)*DW +: DW] = lane_a[{srow, scol}];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) out_data_o <= perm;
    end
  end

endmodule

// File: rtl/pxl_block_mem.sv
module pxl_block_mem #(
  parameter int PIX_W = 8,
  parameter int IMG_W = 64,
  parameter int IMG_H = 64,
  parameter int BLK   = 4,
  localparam int XW = $clog2(IMG_W),
  localparam int YW = $clog2(IMG_H),
  localparam int BW = $clog2(BLK),
  localparam int NB = BLK * BLK,
  localparam int AW = (XW - BW) + (YW - BW)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en_i,
  input  logic [XW-1:0]       wr_x_i,
  input  logic [YW-1:0]       wr_y_i,
  input  logic [PIX_W-1:0]    wr_data_i,
  input  logic                rd_en_i,
  input  logic [XW-1:0]       rd_x_i,
  input  logic [YW-1:0]       rd_y_i,
  output logic                rd_valid_o,
  output logic [NB*PIX_W-1:0] rd_data_o
);

  logic [NB-1:0]       bank_we;
  logic [AW-1:0]       bank_waddr;
  logic [NB*AW-1:0]    bank_raddr;
  logic [NB*PIX_W-1:0] bank_q;

  logic          s1_valid;
  logic [BW-1:0] s1_xo, s1_yo;

  pxl_wr_route #(.BLK(BLK), .XW(XW), .YW(YW)) u_wr_route (
    .wr_en_i (wr_en_i),
    .x_i     (wr_x_i),
    .y_i     (wr_y_i),
    .we_o    (bank_we),
    .waddr_o (bank_waddr)
  );

  pxl_rd_addr #(.BLK(BLK), .XW(XW), .YW(YW)) u_rd_addr (
    .x_i     (rd_x_i),
    .y_i     (rd_y_i),
    .raddr_o (bank_raddr)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    pxl_bank #(.DW(PIX_W), .AW(AW)) u_bank (
      .clk     (clk),
      .we_i    (bank_we[b]),
      .waddr_i (bank_waddr),
      .wdata_i (wr_data_i),
      .raddr_i (bank_raddr[b*AW +: AW]),
      .rdata_o (bank_q[b*PIX_W +: PIX_W])
    );
  end

  // Stage 1: carry the request's tile offset alongside the bank access.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_xo    <= '0;
      s1_yo    <= '0;
    end else begin
      s1_valid <= rd_en_i;
      s1_xo    <= rd_x_i[BW-1:0];
      s1_yo    <= rd_y_i[BW-1:0];
    end
  end

  pxl_reorder #(.BLK(BLK), .DW(PIX_W)) u_reorder (
    .clk         (clk),
    .rst         (rst),
    .in_valid_i  (s1_valid),
    .xo_i        (s1_xo),
    .yo_i        (s1_yo),
    .lanes_i     (bank_q),
    .out_valid_o (rd_valid_o),
    .out_data_o  (rd_data_o)
  );

endmodule

// File: rtl/pxl_block_mem_chk.sv
module pxl_block_mem_chk #(
  parameter int NB = 16,
  parameter int OW = 128
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_en_i,
  input logic          wr_en_i,
  input logic          rd_valid_o,
  input logic [OW-1:0] rd_data_o,
  input logic [NB-1:0] bank_we
);

  logic [1:0] warm;

  always_ff @(posedge clk) begin
    if (rst) warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R4
  valid_has_request_chk: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3) && rd_valid_o |-> $past(rd_en_i, 2));

  // R4
  request_gives_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |=> ##1 rd_valid_o);

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (warm != 2'd0) && !rd_valid_o |-> $stable(rd_data_o));

  // R8
  single_bank_we_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_we));

  // R5
  write_reaches_bank_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |-> $countones(bank_we) == 1);

endmodule

bind pxl_block_mem pxl_block_mem_chk #(.NB(NB), .OW(NB*PIX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_en_i    (rd_en_i),
  .wr_en_i    (wr_en_i),
  .rd_valid_o (rd_valid_o),
  .rd_data_o  (rd_data_o),
  .bank_we    (bank_we)
);

// File: tb/tb_pxl_block_mem.sv
module tb_pxl_block_mem;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  localparam int W  = 64;
  localparam int H  = 64;
  localparam int B  = 4;
  localparam int NB = B * B;
  localparam int XW = $clog2(W);
  localparam int YW = $clog2(H);
  localparam int OW = NB * PW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [XW-1:0] wr_x = '0;
  logic [YW-1:0] wr_y = '0;
  logic [PW-1:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic [XW-1:0] rd_x = '0;
  logic [YW-1:0] rd_y = '0;
  logic rd_valid;
  logic [OW-1:0] rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  pxl_block_mem #(.PIX_W(PW), .IMG_W(W), .IMG_H(H), .BLK(B)) dut (
    .clk(clk), .rst(rst),
    .wr_en_i(wr_en), .wr_x_i(wr_x), .wr_y_i(wr_y), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_x_i(rd_x), .rd_y_i(rd_y),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  int n_tests = 0;
  int n_fail  = 0;
  string cur_tag = "R7";
  bit mon_on = 1'b0;

  logic [PW-1:0] shadow [W*H];
  logic en1 = 1'b0, en2 = 1'b0;
  logic [OW-1:0] exp1 = '0, exp2 = '0, last_exp = '0;

  function automatic logic [PW-1:0] pat(int x, int y);
    return PW'((x * 5 + y * 11 + (x ^ y) * 3) & 255);
  endfunction

  function automatic logic [OW-1:0] block_of(int x0, int y0);
    logic [OW-1:0] res;
    res = '0;
    for (int r = 0; r < B; r++)
      for (int c = 0; c < B; c++)
        res[(r*B + c)*PW +: PW] = shadow[(y0 + r)*W + (x0 + c)];
    return res;
  endfunction

  task automatic check(bit ok, string tag, logic [OW-1:0] act, logic [OW-1:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
    end
  endtask

  // Reference model: expected block is taken before the same-edge write.
  always @(posedge clk) begin
    if (rst) begin
      en1 = 1'b0;
      en2 = 1'b0;
    end else begin
      en2  = en1;
      exp2 = exp1;
      en1  = rd_en;
      if (rd_en) exp1 = block_of(int'(rd_x), int'(rd_y));
      if (wr_en) shadow[int'(wr_y)*W + int'(wr_x)] = wr_data;
    end
  end

  always @(negedge clk) begin
    if (mon_on) begin
      check(rd_valid == en2, {cur_tag, " R4 valid"}, OW'(rd_valid), OW'(en2));
      if (en2) begin
        check(rd_data === exp2, {cur_tag, " R1 block"}, rd_data, exp2);
        last_exp = exp2;
      end else begin
        check(rd_data === last_exp, {cur_tag, " R7 hold"}, rd_data, last_exp);
      end
    end
  end

  task automatic cyc(bit we, int wx, int wy, int wd, bit re, int rx, int ry);
    @(negedge clk);
    wr_en   = we;
    wr_x    = XW'(wx);
    wr_y    = YW'(wy);
    wr_data = PW'(wd);
    rd_en   = re;
    rd_x    = XW'(rx);
    rd_y    = YW'(ry);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R3 watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    // R7: reset state
    check(rd_valid == 1'b0, "R7 reset valid", OW'(rd_valid), '0);
    check(rd_data === '0, "R7 reset data", rd_data, '0);
    @(negedge clk);
    rst = 1'b0;
    mon_on = 1'b1;

    // R5: load image pixel by pixel
    cur_tag = "R5";
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++)
        cyc(1, x, y, int'(pat(x, y)), 0, 0, 0);
    idle(3);

    // R1: aligned windows
    cur_tag = "R1";
    for (int y0 = 0; y0 <= H - B; y0 += B)
      for (int x0 = 0; x0 <= W - B; x0 += B)
        cyc(0, 0, 0, 0, 1, x0, y0);
    idle(3);

    // R2: every legal origin, back to back
    cur_tag = "R2";
    for (int y0 = 0; y0 <= H - B; y0++)
      for (int x0 = 0; x0 <= W - B; x0++)
        cyc(0, 0, 0, 0, 1, x0, y0);
    idle(3);

    // R3: unrelated origins on consecutive clocks
    cur_tag = "R3";
    for (int k = 0; k < 600; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(0, 0, 0, 0, 1, int'(lfsr[7:0]) % (W - B + 1), int'(lfsr[15:8]) % (H - B + 1));
    end
    idle(3);

    // R4: isolated request, strobe checked every cycle around it
    cur_tag = "R4";
    cyc(0, 0, 0, 0, 1, 13, 22);
    idle(6);
    cyc(0, 0, 0, 0, 1, 61 - 1, 3);
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 7, 59);
    idle(5);

    // R6: write inside the window on the read's own edge returns old data
    cur_tag = "R6";
    cyc(1, 14, 23, 8'hA5, 1, 13, 22);
    // R5: the following read sees the new value
    cur_tag = "R5";
    cyc(0, 0, 0, 0, 1, 13, 22);
    idle(4);

    // R8: single write leaves neighbours untouched
    cur_tag = "R8";
    cyc(1, 30, 30, 8'h3C, 0, 0, 0);
    for (int y0 = 27; y0 <= 30; y0++)
      for (int x0 = 27; x0 <= 30; x0++)
        cyc(0, 0, 0, 0, 1, x0, y0);
    cyc(1, 63, 63, 8'h01, 1, 60, 60);
    cyc(0, 0, 0, 0, 1, 60, 60);
    idle(5);

    mon_on = 1'b0;
    finish_run();
  end

endmodule